// File: doc/BRIEF.md
# Access Domain and Permission Checker

This block decides, one cycle after a translation lookaside buffer hit, whether a memory access may go ahead. It takes the kind of access (instruction fetch, data read or data write), the processor's privilege state and a per-request force-user flag, the domain access control word, and the attributes of the matching entry: domain index, three-bit permission code, execute-never bit and a secure-class bit. From these it reports pass or fault. On a fault it also reports whether the fault is a prefetch abort or a data abort, and which fault class applies. A reserved encoding raises a separate unpredictable flag.

Checks run in a fixed order. The alignment check runs first. Next comes the two-bit domain field chosen by the entry's domain index. The permission code is decoded last, and only for domains marked as client. When address translation is turned off, the block passes the virtual address straight through as the physical address. It also computes the cacheability decision from the remap controls. All results leave through one registered stage, so a request presented in cycle N is answered in cycle N+1.

Top module: `acc_perm_check`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_valid`, `rsp_pass`, `rsp_fault`, `rsp_unpred` and `rsp_uncache` are 0.
- R2: A request with `req_valid` high is answered exactly one clock later with `rsp_valid` high. For a valid response, exactly one of `rsp_pass`, `rsp_fault` and `rsp_unpred` is 1. A passing or unpredictable response drives `rsp_cls` to 0, and `rsp_prefetch` is 0 unless `rsp_fault` is 1.
- R3: `req_kind` encodes 00 as read, 01 as write, 10 as fetch and 11 as read. A read or write raises an alignment fault when `vaddr` AND `align_mask` is nonzero and either `align_glob` is 1 or `unaligned_ok` is 0. The fault is reported as a data abort with class 1. A fetch never raises an alignment fault.
- R4: An access is privileged only when `cpu_user` is 0 and `force_user` is 0.
- R5: The domain field is `dom_ctrl[2*ent_domain +: 2]`. Field 00 raises a domain fault. A fetch reports it as a prefetch abort and other kinds report it as a data abort. The class is 2 when `ent_secure` is 1 and 3 otherwise.
- R6: Domain field 11 passes the access without decoding the permission code or checking execute-never.
- R7: Domain field 10 sets `rsp_unpred`. For domain field 01, an effective permission code of 4 also sets `rsp_unpred`.
- R8: When `afe_en` is 1, bit 0 of the permission code is forced to 1 before decoding.
- R9: For domain field 01, the effective permission code denies access as follows: code 0 always; code 1 when unprivileged; code 2 for unprivileged writes; code 3 never; code 5 when unprivileged or writing; codes 6 and 7 for writes.
- R10: A fetch that is denied, or whose entry has `ent_xn` set, gives a prefetch permission fault. Any other denial gives a data permission fault. The class is 4 when `ent_secure` is 1 and 5 otherwise.
- R11: With `mmu_on` at 0, a request without an alignment fault passes and `rsp_paddr` equals `vaddr`. `rsp_uncache` is 1 when `remap_en` is 0. When `remap_en` is 1, `rsp_uncache` is 1 if `attr_in0` is 0, `attr_out0` is 0 or `type0` is not 2. With `mmu_on` at 1, `rsp_uncache` is 0.
- R12: With `mmu_on` at 1, `rsp_paddr` is `ent_pfn` concatenated with the low `PAGE_W` bits of `vaddr`.
- R13: When several faults apply, the alignment fault wins over the domain result, and the domain result wins over the permission decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| cpu_user | input | 1 | Processor is in user mode |
| force_user | input | 1 | Request must be treated as unprivileged |
| mmu_on | input | 1 | Translation enabled |
| align_glob | input | 1 | Global alignment checking |
| unaligned_ok | input | 1 | Request tolerates unaligned addresses |
| align_mask | input | ALIGN_W | Low address bits that must be zero |
| vaddr | input | ADDR_W | Virtual address |
| dom_ctrl | input | 2*NUM_DOM | Two-bit access field per domain |
| ent_domain | input | DOM_IDX_W | Entry's domain index |
| ent_perm | input | 3 | Entry's permission code |
| ent_xn | input | 1 | Entry forbids execution |
| ent_secure | input | 1 | Selects the secure fault class variant |
| ent_pfn | input | ADDR_W-PAGE_W | Entry's physical frame number |
| afe_en | input | 1 | Force permission bit 0 high |
| remap_en | input | 1 | Attribute remap enabled (translation off) |
| attr_in0 | input | 1 | Inner attribute 0 |
| attr_out0 | input | 1 | Outer attribute 0 |
| type0 | input | 2 | Memory type field 0 |
| rsp_valid | output | 1 | Result present |
| rsp_pass | output | 1 | Access allowed |
| rsp_fault | output | 1 | Fault class valid |
| rsp_prefetch | output | 1 | Fault is a prefetch abort (else data abort) |
| rsp_cls | output | 3 | 1 align, 2 domain secure, 3 domain non-secure, 4 permission secure, 5 permission non-secure |
| rsp_unpred | output | 1 | Reserved encoding seen |
| rsp_uncache | output | 1 | Untranslated access is uncacheable |
| rsp_paddr | output | ADDR_W | Physical address |

## Verification
Alignment and the domain/permission decision can both apply to the same request, because the alignment check does not depend on the entry. The bench provokes this with misaligned writes aimed at a no-access domain. It also sends misaligned reads that are denied by permission code 0, and misaligned reads with translation off. Each result is judged by requiring class 1 with a data abort and no pass.

// File: rtl/apc_pkg.sv
package apc_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RD2   = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    DOM_NOACC  = 2'b00,
    DOM_CLIENT = 2'b01,
    DOM_RSVD   = 2'b10,
    DOM_MGR    = 2'b11
  } dom_fld_e;

  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_ALIGN   = 3'd1,
    FC_DOM_S   = 3'd2,
    FC_DOM_NS  = 3'd3,
    FC_PERM_S  = 3'd4,
    FC_PERM_NS = 3'd5
  } fcls_e;

  localparam int PERM_W = 3;

endpackage

// File: rtl/apc_align.sv
module apc_align #(
  parameter int ALIGN_W = 3
) (
  input  logic               is_fetch,
  input  logic               glob_en,
  input  logic               unaligned_ok,
  input  logic [ALIGN_W-1:0] mask,
  input  logic [ALIGN_W-1:0] low_addr,
  output logic               misaligned
);
  logic enforce;
  assign enforce    = glob_en || !unaligned_ok;
  assign misaligned = !is_fetch && enforce && ((low_addr & mask) != '0);
endmodule

// File: rtl/apc_domain.sv
module apc_domain #(
  parameter int NUM_DOM = 16,
  parameter int IDX_W   = 4
) (
  input  logic [2*NUM_DOM-1:0] dom_ctrl,
  input  logic [IDX_W-1:0]     idx,
  output apc_pkg::dom_fld_e    field
);
  logic [1:0] fld [NUM_DOM];

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_fld
    assign fld[g] = dom_ctrl[2*g +: 2];
  end

  always_comb begin
    if (32'(idx) < NUM_DOM) field = apc_pkg::dom_fld_e'(fld[idx]);
    else                    field = apc_pkg::DOM_NOACC;
  end
endmodule

// File: rtl/apc_perm.sv
module apc_perm (
  input  logic [apc_pkg::PERM_W-1:0] perm_code,
  input  logic                       afe_en,
  input  logic                       priv,
  input  logic                       is_write,
  output logic                       deny,
  output logic                       rsvd
);
  logic [apc_pkg::PERM_W-1:0] eff;
  assign eff = perm_code | {{(apc_pkg::PERM_W-1){1'b0}}, afe_en};

  always_comb begin
    deny = 1'b0;
    rsvd = 1'b0;
    case (eff)
      3'd0:    deny = 1'b1;
      3'd1:    deny = !priv;
      3'd2:    deny = !priv && is_write;
      3'd3:    deny = 1'b0;
      3'd4:    rsvd = 1'b1;
      3'd5:    deny = !priv || is_write;
      default: deny = is_write;
    endcase
  end
endmodule

// File: rtl/apc_flat_attr.sv
module apc_flat_attr (
  input  logic       remap_en,
  input  logic       attr_in0,
  input  logic       attr_out0,
  input  logic [1:0] type0,
  output logic       uncache
);
  assign uncache = !remap_en || !attr_in0 || !attr_out0 || (type0 != 2'd2);
endmodule

// File: rtl/acc_perm_check.sv
module acc_perm_check #(
  parameter int ADDR_W  = 32,
  parameter int NUM_DOM = 16,
  parameter int ALIGN_W = 3,
  parameter int PAGE_W  = 12,
  localparam int DOM_IDX_W = $clog2(NUM_DOM),
  localparam int PFN_W     = ADDR_W - PAGE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [1:0]           req_kind,
  input  logic                 cpu_user,
  input  logic                 force_user,
  input  logic                 mmu_on,
  input  logic                 align_glob,
  input  logic                 unaligned_ok,
  input  logic [ALIGN_W-1:0]   align_mask,
  input  logic [ADDR_W-1:0]    vaddr,
  input  logic [2*NUM_DOM-1:0] dom_ctrl,
  input  logic [DOM_IDX_W-1:0] ent_domain,
  input  logic [2:0]           ent_perm,
  input  logic                 ent_xn,
  input  logic                 ent_secure,
  input  logic [PFN_W-1:0]     ent_pfn,
  input  logic                 afe_en,
  input  logic                 remap_en,
  input  logic                 attr_in0,
  input  logic                 attr_out0,
  input  logic [1:0]           type0,
  output logic                 rsp_valid,
  output logic                 rsp_pass,
  output logic                 rsp_fault,
  output logic                 rsp_prefetch,
  output logic [2:0]           rsp_cls,
  output logic                 rsp_unpred,
  output logic                 rsp_uncache,
  output logic [ADDR_W-1:0]    rsp_paddr
);
  import apc_pkg::*;

  logic     is_fetch, is_write, priv;
  logic     misal, deny, perm_rsvd, flat_unc;
  dom_fld_e dom_fld;

  assign is_fetch = (req_kind == KIND_FETCH);
  assign is_write = (req_kind == KIND_WRITE);
  assign priv     = !cpu_user && !force_user;

  apc_align #(.ALIGN_W(ALIGN_W)) u_align (
    .is_fetch     (is_fetch),
    .glob_en      (align_glob),
    .unaligned_ok (unaligned_ok),
    .mask         (align_mask),
    .low_addr     (vaddr[ALIGN_W-1:0]),
    .misaligned   (misal)
  );

  apc_domain #(.NUM_DOM(NUM_DOM), .IDX_W(DOM_IDX_W)) u_dom (
    .dom_ctrl (dom_ctrl),
    .idx      (ent_domain),
    .field    (dom_fld)
  );

  apc_perm u_perm (
    .perm_code (ent_perm),
    .afe_en    (afe_en),
    .priv      (priv),
    .is_write  (is_write),
    .deny      (deny),
    .rsvd      (perm_rsvd)
  );

  apc_flat_attr u_flat (
    .remap_en  (remap_en),
    .attr_in0  (attr_in0),
    .attr_out0 (attr_out0),
    .type0     (type0),
    .uncache   (flat_unc)
  );

  logic          n_pass, n_fault, n_pf, n_unp, n_unc;
  fcls_e         n_cls;
  logic [ADDR_W-1:0] n_paddr;

  assign n_paddr = mmu_on ? {ent_pfn, vaddr[PAGE_W-1:0]} : vaddr;

  always_comb begin
    n_pass  = 1'b0;
    n_fault = 1'b0;
    n_pf    = 1'b0;
    n_unp   = 1'b0;
    n_unc   = 1'b0;
    n_cls   = FC_NONE;
    if (misal) begin
      n_fault = 1'b1;
      n_cls   = FC_ALIGN;
    end else if (!mmu_on) begin
      n_pass = 1'b1;
      n_unc  = flat_unc;
    end else begin
      case (dom_fld)
        DOM_NOACC: begin
          n_fault = 1'b1;
          n_pf    = is_fetch;
          n_cls   = ent_secure ? FC_DOM_S : FC_DOM_NS;
        end
        DOM_RSVD: n_unp  = 1'b1;
        DOM_MGR:  n_pass = 1'b1;
        default: begin
          if (perm_rsvd) begin
            n_unp = 1'b1;
          end else if (deny || (is_fetch && ent_xn)) begin
            n_fault = 1'b1;
            n_pf    = is_fetch;
            n_cls   = ent_secure ? FC_PERM_S : FC_PERM_NS;
          end else begin
            n_pass = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_pass     <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_prefetch <= 1'b0;
      rsp_cls      <= FC_NONE;
      rsp_unpred   <= 1'b0;
      rsp_uncache  <= 1'b0;
      rsp_paddr    <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_pass     <= req_valid && n_pass;
      rsp_fault    <= req_valid && n_fault;
      rsp_prefetch <= req_valid && n_pf;
      rsp_cls      <= req_valid ? n_cls : FC_NONE;
      rsp_unpred   <= req_valid && n_unp;
      rsp_uncache  <= req_valid && n_unc;
      if (req_valid) rsp_paddr <= n_paddr;
    end
  end

endmodule

// File: rtl/apc_sva.sv
module apc_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              mmu_on,
  input logic [ADDR_W-1:0] vaddr,
  input logic              rsp_valid,
  input logic              rsp_pass,
  input logic              rsp_fault,
  input logic              rsp_prefetch,
  input logic [2:0]        rsp_cls,
  input logic              rsp_unpred,
  input logic              rsp_uncache,
  input logic [ADDR_W-1:0] rsp_paddr
);
  // R2
  answer_follows_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_pass, rsp_fault, rsp_unpred}) == 1);

  // R2
  no_cls_on_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_fault |-> (rsp_cls == 3'd0 && !rsp_prefetch));

  // R3
  align_is_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault && rsp_cls == 3'd1) |-> !rsp_prefetch);

  // R11
  flat_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mmu_on) |=> rsp_paddr == $past(vaddr));

  // R11
  cache_only_flat_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mmu_on) |=> !rsp_uncache);
endmodule

bind acc_perm_check apc_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .mmu_on       (mmu_on),
  .vaddr        (vaddr),
  .rsp_valid    (rsp_valid),
  .rsp_pass     (rsp_pass),
  .rsp_fault    (rsp_fault),
  .rsp_prefetch (rsp_prefetch),
  .rsp_cls      (rsp_cls),
  .rsp_unpred   (rsp_unpred),
  .rsp_uncache  (rsp_uncache),
  .rsp_paddr    (rsp_paddr)
);

// File: tb/sim_acc_perm_check.sv
module sim_acc_perm_check;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic        cpu_user, force_user, mmu_on, align_glob, unaligned_ok;
  logic [2:0]  align_mask;
  logic [31:0] vaddr, dom_ctrl;
  logic [3:0]  ent_domain;
  logic [2:0]  ent_perm;
  logic        ent_xn, ent_secure, afe_en, remap_en, attr_in0, attr_out0;
  logic [19:0] ent_pfn;
  logic [1:0]  type0;
  logic        rsp_valid, rsp_pass, rsp_fault, rsp_prefetch, rsp_unpred, rsp_uncache;
  logic [2:0]  rsp_cls;
  logic [31:0] rsp_paddr;

  always #10 clk = ~clk;

  acc_perm_check u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .cpu_user(cpu_user), .force_user(force_user), .mmu_on(mmu_on),
    .align_glob(align_glob), .unaligned_ok(unaligned_ok), .align_mask(align_mask),
    .vaddr(vaddr), .dom_ctrl(dom_ctrl), .ent_domain(ent_domain), .ent_perm(ent_perm),
    .ent_xn(ent_xn), .ent_secure(ent_secure), .ent_pfn(ent_pfn), .afe_en(afe_en),
    .remap_en(remap_en), .attr_in0(attr_in0), .attr_out0(attr_out0), .type0(type0),
    .rsp_valid(rsp_valid), .rsp_pass(rsp_pass), .rsp_fault(rsp_fault),
    .rsp_prefetch(rsp_prefetch), .rsp_cls(rsp_cls), .rsp_unpred(rsp_unpred),
    .rsp_uncache(rsp_uncache), .rsp_paddr(rsp_paddr)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        user, fu, mmu, acen, aua;
    logic [2:0]  amask;
    logic [31:0] va, dctl;
    logic [3:0]  dom;
    logic [2:0]  perm;
    logic        xn, sec, afe, remap, in0, out0;
    logic [1:0]  ty0;
    logic [19:0] pfn;
  } stim_t;

  typedef struct {
    logic        pass, fault, pf, unp, unc;
    logic [2:0]  cls;
    logic [31:0] pa;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  function automatic stim_t base();
    stim_t s;
    s.kind = 2'b00; s.user = 0; s.fu = 0; s.mmu = 1; s.acen = 0; s.aua = 1;
    s.amask = 3'b000; s.va = 32'h1234_5678; s.dctl = 32'h5555_5555; s.dom = 4'd5;
    s.perm = 3'd3; s.xn = 0; s.sec = 0; s.afe = 0; s.remap = 0; s.in0 = 1;
    s.out0 = 1; s.ty0 = 2'd2; s.pfn = 20'hABCDE;
    return s;
  endfunction

  function automatic logic [31:0] set_dom(logic [31:0] w, int d, logic [1:0] v);
    logic [31:0] r;
    r = w & ~(32'h3 << (2*d));
    r = r | (32'(v) << (2*d));
    return r;
  endfunction

  // Expected result derived from the requirement list.
  function automatic exp_t model(stim_t s, string tag);
    exp_t e;
    logic fetch, wr, priv, mis, deny;
    logic [1:0] df;
    logic [2:0] p;
    e.pass = 0; e.fault = 0; e.pf = 0; e.unp = 0; e.unc = 0; e.cls = 3'd0; e.tag = tag;
    e.pa = s.mmu ? {s.pfn, s.va[11:0]} : s.va;               // R11 R12
    fetch = (s.kind == 2'b10);
    wr    = (s.kind == 2'b01);
    priv  = (s.user == 0) && (s.fu == 0);                    // R4
    mis   = !fetch && (s.acen || !s.aua) && ((s.va[2:0] & s.amask) != 0);
    df    = 2'((s.dctl >> (2*s.dom)) & 32'h3);
    p     = s.afe ? (s.perm | 3'b001) : s.perm;              // R8
    if (mis) begin e.fault = 1; e.cls = 3'd1; end            // R3 R13
    else if (!s.mmu) begin
      e.pass = 1;
      e.unc  = !s.remap || !s.in0 || !s.out0 || (s.ty0 != 2'd2);
    end else if (df == 2'b00) begin
      e.fault = 1; e.pf = fetch; e.cls = s.sec ? 3'd2 : 3'd3;
    end else if (df == 2'b10) e.unp = 1;
    else if (df == 2'b11) e.pass = 1;
    else if (p == 3'd4) e.unp = 1;
    else begin
      deny = (p == 0) || (p == 1 && !priv) || (p == 2 && !priv && wr) ||
             (p == 5 && (!priv || wr)) || (p >= 6 && wr);
      if (deny || (fetch && s.xn)) begin
        e.fault = 1; e.pf = fetch; e.cls = s.sec ? 3'd4 : 3'd5;
      end else e.pass = 1;
    end
    return e;
  endfunction

  task automatic send(stim_t s, string tag);
    @(negedge clk);
    req_valid = 1; req_kind = s.kind; cpu_user = s.user; force_user = s.fu;
    mmu_on = s.mmu; align_glob = s.acen; unaligned_ok = s.aua; align_mask = s.amask;
    vaddr = s.va; dom_ctrl = s.dctl; ent_domain = s.dom; ent_perm = s.perm;
    ent_xn = s.xn; ent_secure = s.sec; afe_en = s.afe; remap_en = s.remap;
    attr_in0 = s.in0; attr_out0 = s.out0; type0 = s.ty0; ent_pfn = s.pfn;
    exp_q.push_back(model(s, tag));
  endtask

  // Monitor: one check per result
  always @(negedge clk) begin
    if (!rst && rsp_valid && !done) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2: unexpected response, expected none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rsp_pass !== e.pass || rsp_fault !== e.fault || rsp_prefetch !== e.pf ||
            rsp_unpred !== e.unp || rsp_uncache !== e.unc || rsp_cls !== e.cls ||
            rsp_paddr !== e.pa) begin
          n_bad++;
          $display("FAIL %s: got pass=%b fault=%b pf=%b cls=%0d unp=%b unc=%b pa=%h, expected pass=%b fault=%b pf=%b cls=%0d unp=%b unc=%b pa=%h",
                   e.tag, rsp_pass, rsp_fault, rsp_prefetch, rsp_cls, rsp_unpred,
                   rsp_uncache, rsp_paddr, e.pass, e.fault, e.pf, e.cls, e.unp, e.unc, e.pa);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : drive
    stim_t s;
    rst = 1; req_valid = 0; req_kind = 0; cpu_user = 0; force_user = 0; mmu_on = 0;
    align_glob = 0; unaligned_ok = 1; align_mask = 0; vaddr = 0; dom_ctrl = 0;
    ent_domain = 0; ent_perm = 0; ent_xn = 0; ent_secure = 0; afe_en = 0;
    remap_en = 0; attr_in0 = 0; attr_out0 = 0; type0 = 0; ent_pfn = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (rsp_valid !== 0 || rsp_pass !== 0 || rsp_fault !== 0 || rsp_unpred !== 0 || rsp_uncache !== 0) begin
      n_bad++;
      $display("FAIL R1: got valid=%b pass=%b fault=%b, expected 0 0 0", rsp_valid, rsp_pass, rsp_fault);
    end
    rst = 0;
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 0 || rsp_pass !== 0 || rsp_fault !== 0) begin
      n_bad++;
      $display("FAIL R1: after release got valid=%b, expected 0", rsp_valid);
    end

    // R11: translation off, cacheability
    s = base(); s.mmu = 0; send(s, "R11 remap off");
    s.remap = 1; send(s, "R11 remap cached");
    s.ty0 = 2'd1; send(s, "R11 type not 2");
    s.ty0 = 2'd2; s.in0 = 0; send(s, "R11 inner zero");
    s.in0 = 1; s.out0 = 0; send(s, "R11 outer zero");

    // R3: alignment
    s = base(); s.kind = 2'b01; s.acen = 1; s.amask = 3'b011; s.va = 32'h1000_005A;
    send(s, "R3 write misaligned");
    s.kind = 2'b10; send(s, "R3 fetch ignores alignment");
    s.kind = 2'b00; s.acen = 0; s.aua = 1; send(s, "R3 unaligned allowed");
    s.aua = 0; send(s, "R3 unaligned not allowed");
    s.amask = 3'b100; send(s, "R3 mask clear bit");
    s.kind = 2'b11; s.amask = 3'b010; send(s, "R3 kind 11 as read");

    // R13: alignment and domain/permission faults together
    s = base(); s.kind = 2'b01; s.acen = 1; s.amask = 3'b001; s.va = 32'h0000_0003;
    s.dctl = set_dom(s.dctl, 5, 2'b00); send(s, "R13 align over domain");
    s.dctl = base().dctl; s.perm = 3'd0; s.kind = 2'b00; send(s, "R13 align over permission");
    s.mmu = 0; send(s, "R13 align with translation off");

    // R5: domain field no access
    s = base(); s.dctl = set_dom(s.dctl, 5, 2'b00); s.kind = 2'b10; s.sec = 1;
    send(s, "R5 fetch domain secure");
    s.kind = 2'b00; s.sec = 0; send(s, "R5 read domain nonsecure");
    s = base(); s.dom = 4'd15; s.dctl = set_dom(s.dctl, 15, 2'b00); s.kind = 2'b01;
    send(s, "R5 top domain field");
    s.dom = 4'd14; send(s, "R5 neighbour domain client");

    // R6: manager bypass
    s = base(); s.dctl = set_dom(s.dctl, 5, 2'b11); s.perm = 3'd0; s.xn = 1; s.kind = 2'b10;
    s.user = 1; send(s, "R6 manager fetch xn");
    s.kind = 2'b01; send(s, "R6 manager write perm 0");

    // R7: reserved encodings
    s = base(); s.dctl = set_dom(s.dctl, 5, 2'b10); send(s, "R7 domain 10");
    s = base(); s.perm = 3'd4; send(s, "R7 perm 4");

    // R8: access flag enable
    s = base(); s.perm = 3'd0; s.afe = 1; send(s, "R8 perm 0 forced to 1 priv read");
    s.user = 1; send(s, "R8 perm 0 forced to 1 user read");
    s.user = 0; s.perm = 3'd4; send(s, "R8 perm 4 forced to 5");
    s.kind = 2'b01; send(s, "R8 perm 4 forced to 5 write");

    // R4: force-user flag
    s = base(); s.perm = 3'd1; s.fu = 1; send(s, "R4 force user denied");
    s.fu = 0; send(s, "R4 privileged allowed");
    s.user = 1; send(s, "R4 user mode denied");

    // R9: full permission sweep
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 3; k++) begin
        for (int u = 0; u < 2; u++) begin
          s = base(); s.perm = 3'(p); s.kind = 2'(k); s.user = 1'(u); s.sec = 1'(p % 2);
          send(s, "R9 sweep");
        end
      end
    end

    // R10: execute-never and fetch denial
    s = base(); s.kind = 2'b10; s.xn = 1; s.sec = 1; send(s, "R10 fetch xn secure");
    s.sec = 0; send(s, "R10 fetch xn nonsecure");
    s.kind = 2'b00; send(s, "R10 read ignores xn");
    s = base(); s.kind = 2'b10; s.perm = 3'd0; send(s, "R10 fetch denied");
    s.kind = 2'b01; s.perm = 3'd6; s.sec = 1; send(s, "R10 data write denied");

    // R12: translated address
    s = base(); s.va = 32'hFFFF_F123; s.pfn = 20'h00042; send(s, "R12 frame join");

    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: %0d responses missing, expected 0", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule